// File: doc/BRIEF.md
# Serial Flash Command Decoder with Write Latch and Sector Protection

This block is the slave-side command decoder of a serial NOR flash. It watches a four-wire serial bus (chip select, serial clock, serial data in, serial data out) through synchronisers clocked by the chip's system clock. It shifts in the opcode and address bytes, most significant bit first, on rising serial-clock edges (clock idle low, mode 0). Every command that changes state acts only when chip select is released, and only if the frame ended on a whole byte.

The block holds a write-enable latch and one protection bit for each 64 KB sector. The latch must be set before any array-modifying command or protection change is honoured. It clears itself once such a command has been taken. Program and erase requests are passed to a downstream array controller as a one-cycle permitted or rejected strobe, together with the opcode and address that go with it. A status byte carrying the latch can be read back on serial data out.

Top module: `spi_flash_cmd_frontend`

## Requirements
- R1: After reset the write-enable latch is 0, every sector protection bit is 1 (protected), `spi_miso_oe`, `spi_miso`, `cmd_ok` and `cmd_rej` are 0, and a reset taken later puts back protection on sectors that were unprotected.
- R2: Opcode 06h sets the write-enable latch when chip select is released after a whole number of bytes; trailing bytes are ignored.
- R3: Opcode 04h clears the write-enable latch at the chip-select release, not at its last bit; any bytes after the opcode are ignored.
- R4: A release after a bit count that is not a multiple of eight, or before eight bits, aborts the command, and the latch keeps its value.
- R5: Opcode 05h returns a status byte on `spi_miso`, MSB first, bit 1 = write-enable latch and all other bits 0. The byte repeats for as long as the clock runs, and each bit is valid before the rising edge that follows the falling edge that launched it.
- R6: `spi_miso_oe` is 1 while chip select is active and 0 while it is inactive (serial data out released).
- R7: Opcode 36h (lock) sets and opcode 39h (unlock) clears the protection bit of the sector selected by address bits [22:16] of the 3-byte address that follows. This happens only if the latch is 1; with the latch 0 nothing changes.
- R8: Opcodes 02h (program), 20h and D8h (erase) with at least 3 address bytes give exactly one single-cycle strobe at release: `cmd_ok` if the latch is 1 and the target sector bit is 0, `cmd_rej` otherwise. `cmd_op` and `cmd_addr` hold that command's opcode and 24-bit address from then on.
- R9: A lock, unlock, program or erase command with full framing, taken while the latch is 1, clears the latch, even when the sector is protected.
- R10: A lock, unlock, program or erase frame with fewer than 3 address bytes or a misaligned release has no effect: no strobe, and no change to the latch or the protection bits.
- R11: Any other opcode leaves the latch, the protection bits and the strobes untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out (status bits) |
| spi_miso_oe | output | 1 | Output enable for serial data out |
| cmd_ok | output | 1 | One-cycle strobe: program/erase permitted |
| cmd_rej | output | 1 | One-cycle strobe: program/erase rejected |
| cmd_op | output | 8 | Opcode of the last strobed request |
| cmd_addr | output | 24 | Address of the last strobed request |

## Verification
Serial-bus pins pass through a two-stage synchroniser and one edge-detect stage. A chip-select release therefore updates the latch, the protection bits and the strobes about four system clocks later. A status bit reaches `spi_miso` about four clocks after the falling serial edge that launches it. The bench drives each serial half-period as eight system clocks. It samples `spi_miso` just before the next rising serial edge and waits 32 clocks after every release before it reads status or counts strobes. Strobes are counted on every clock edge by a monitor, so each frame is judged by the change in the permitted and rejected counts.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [7:0] {
        OP_PROGRAM     = 8'h02,
        OP_CLR_WEL     = 8'h04,
        OP_GET_STATUS  = 8'h05,
        OP_SET_WEL     = 8'h06,
        OP_ERASE_SMALL = 8'h20,
        OP_LOCK_SECT   = 8'h36,
        OP_UNLOCK_SECT = 8'h39,
        OP_ERASE_LARGE = 8'hD8
    } op_e;

    localparam int STAT_WEL_BIT = 1;

    function automatic logic is_array_op(input logic [7:0] op);
        return (op == OP_PROGRAM) || (op == OP_ERASE_SMALL) || (op == OP_ERASE_LARGE);
    endfunction

    function automatic logic [7:0] status_byte(input logic wel);
        logic [7:0] s;
        s = '0;
        s[STAT_WEL_BIT] = wel;
        return s;
    endfunction

endpackage

// File: rtl/spi_frame_rx.sv
module spi_frame_rx #(
    parameter int ADDR_BYTES  = 3,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int FRAME_BYTES = 1 + ADDR_BYTES,
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              cs_active,
    output logic              cs_rise,
    output logic              sclk_fall,
    output logic [7:0]        opcode,
    output logic [ADDR_W-1:0] addr,
    output logic [2:0]        bitpos,
    output logic [CNT_W-1:0]  nbytes
);

    typedef struct packed {
        logic [SYNC_STAGES:0]   cs_p;
        logic [SYNC_STAGES:0]   sclk_p;
        logic [SYNC_STAGES-1:0] mosi_p;
        logic [6:0]             shreg;
        logic [2:0]             bitpos;
        logic [CNT_W-1:0]       nbytes;
        logic [7:0]             opcode;
        logic [ADDR_W-1:0]      addr;
    } rx_t;

    rx_t q, d;
    logic cs_cur, sclk_cur, sclk_rise, mosi_cur;
    logic [7:0] new_byte;

    always_comb begin
        cs_cur    = q.cs_p[SYNC_STAGES-1];
        sclk_cur  = q.sclk_p[SYNC_STAGES-1];
        mosi_cur  = q.mosi_p[SYNC_STAGES-1];
        cs_active = !cs_cur;
        cs_rise   = cs_cur && !q.cs_p[SYNC_STAGES];
        sclk_rise = sclk_cur && !q.sclk_p[SYNC_STAGES];
        sclk_fall = !sclk_cur && q.sclk_p[SYNC_STAGES];
        new_byte  = {q.shreg, mosi_cur};

        d        = q;
        d.cs_p   = {q.cs_p[SYNC_STAGES-1:0], spi_cs_n};
        d.sclk_p = {q.sclk_p[SYNC_STAGES-1:0], spi_sclk};
        d.mosi_p = {q.mosi_p[SYNC_STAGES-2:0], spi_mosi};

        if (cs_cur) begin
            d.shreg  = '0;
            d.bitpos = '0;
            d.nbytes = '0;
        end else if (sclk_rise) begin
            d.shreg  = new_byte[6:0];
            d.bitpos = q.bitpos + 3'd1;
            if (q.bitpos == 3'd7) begin
                if (q.nbytes == '0) begin
                    d.opcode = new_byte;
                end else if (q.nbytes < CNT_W'(FRAME_BYTES)) begin
                    d.addr = {q.addr[ADDR_W-9:0], new_byte};
                end
                if (q.nbytes < CNT_W'(FRAME_BYTES)) begin
                    d.nbytes = q.nbytes + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.cs_p   <= '1;
        end else begin
            q <= d;
        end
    end

    assign opcode = q.opcode;
    assign addr   = q.addr;
    assign bitpos = q.bitpos;
    assign nbytes = q.nbytes;

endmodule

// File: rtl/flash_cmd_exec.sv
module flash_cmd_exec
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    parameter int NUM_SECT   = 128,
    parameter int SECT_LSB   = 16,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int FRAME_BYTES = 1 + ADDR_BYTES,
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1),
    localparam int SECT_W      = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_rise,
    input  logic [7:0]          opcode,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2:0]          bitpos,
    input  logic [CNT_W-1:0]    nbytes,
    output logic                wel,
    output logic [NUM_SECT-1:0] prot,
    output logic                cmd_ok,
    output logic                cmd_rej,
    output logic [7:0]          cmd_op,
    output logic [ADDR_W-1:0]   cmd_addr
);

    typedef struct packed {
        logic                wel;
        logic [NUM_SECT-1:0] prot;
        logic                ok;
        logic                rej;
        logic [7:0]          op;
        logic [ADDR_W-1:0]   addr;
    } ex_t;

    ex_t q, d;
    logic aligned, full;
    logic [SECT_W-1:0] sect;

    always_comb begin
        aligned = (bitpos == 3'd0) && (nbytes != '0);
        full    = (nbytes == CNT_W'(FRAME_BYTES));
        sect    = addr[SECT_LSB +: SECT_W];

        d     = q;
        d.ok  = 1'b0;
        d.rej = 1'b0;

        if (cs_rise && aligned) begin
            if (opcode == OP_SET_WEL) begin
                d.wel = 1'b1;
            end else if (opcode == OP_CLR_WEL) begin
                d.wel = 1'b0;
            end else if ((opcode == OP_LOCK_SECT) || (opcode == OP_UNLOCK_SECT)) begin
                if (full && q.wel) begin
                    d.prot[sect] = (opcode == OP_LOCK_SECT);
                    d.wel        = 1'b0;
                end
            end else if (is_array_op(opcode)) begin
                if (full) begin
                    d.op   = opcode;
                    d.addr = addr;
                    d.wel  = 1'b0;
                    if (q.wel && !q.prot[sect]) begin
                        d.ok = 1'b1;
                    end else begin
                        d.rej = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.prot <= '1;
        end else begin
            q <= d;
        end
    end

    assign wel      = q.wel;
    assign prot     = q.prot;
    assign cmd_ok   = q.ok;
    assign cmd_rej  = q.rej;
    assign cmd_op   = q.op;
    assign cmd_addr = q.addr;

endmodule

// File: rtl/flash_status_tx.sv
module flash_status_tx
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_BYTES = 3,
    localparam int FRAME_BYTES = 1 + ADDR_BYTES,
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_active,
    input  logic             sclk_fall,
    input  logic [7:0]       opcode,
    input  logic [2:0]       bitpos,
    input  logic [CNT_W-1:0] nbytes,
    input  logic             wel,
    output logic             spi_miso,
    output logic             spi_miso_oe
);

    typedef struct packed {
        logic miso;
        logic oe;
    } tx_t;

    tx_t q, d;
    logic [7:0] stat;

    always_comb begin
        stat = status_byte(wel);
        d    = q;
        d.oe = cs_active;
        if (!cs_active) begin
            d.miso = 1'b0;
        end else if (sclk_fall && (nbytes != '0) && (opcode == OP_GET_STATUS)) begin
            d.miso = stat[3'd7 - bitpos];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign spi_miso    = q.miso;
    assign spi_miso_oe = q.oe;

endmodule

// File: rtl/spi_flash_cmd_frontend.sv
module spi_flash_cmd_frontend #(
    parameter int ADDR_BYTES  = 3,
    parameter int NUM_SECT    = 128,
    parameter int SECT_LSB    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W      = 8 * ADDR_BYTES,
    localparam int FRAME_BYTES = 1 + ADDR_BYTES,
    localparam int CNT_W       = $clog2(FRAME_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic              cmd_ok,
    output logic              cmd_rej,
    output logic [7:0]        cmd_op,
    output logic [ADDR_W-1:0] cmd_addr
);

    logic                cs_active, cs_rise, sclk_fall, wel;
    logic [7:0]          opcode;
    logic [ADDR_W-1:0]   addr;
    logic [2:0]          bitpos;
    logic [CNT_W-1:0]    nbytes;
    logic [NUM_SECT-1:0] prot;

    spi_frame_rx #(
        .ADDR_BYTES (ADDR_BYTES),
        .SYNC_STAGES(SYNC_STAGES)
    ) i_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_cs_n (spi_cs_n),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .cs_active(cs_active),
        .cs_rise  (cs_rise),
        .sclk_fall(sclk_fall),
        .opcode   (opcode),
        .addr     (addr),
        .bitpos   (bitpos),
        .nbytes   (nbytes)
    );

    flash_cmd_exec #(
        .ADDR_BYTES(ADDR_BYTES),
        .NUM_SECT  (NUM_SECT),
        .SECT_LSB  (SECT_LSB)
    ) i_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_rise (cs_rise),
        .opcode  (opcode),
        .addr    (addr),
        .bitpos  (bitpos),
        .nbytes  (nbytes),
        .wel     (wel),
        .prot    (prot),
        .cmd_ok  (cmd_ok),
        .cmd_rej (cmd_rej),
        .cmd_op  (cmd_op),
        .cmd_addr(cmd_addr)
    );

    flash_status_tx #(
        .ADDR_BYTES(ADDR_BYTES)
    ) i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_active  (cs_active),
        .sclk_fall  (sclk_fall),
        .opcode     (opcode),
        .bitpos     (bitpos),
        .nbytes     (nbytes),
        .wel        (wel),
        .spi_miso   (spi_miso),
        .spi_miso_oe(spi_miso_oe)
    );

endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int NUM_SECT = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_rise,
    input logic                wel,
    input logic [NUM_SECT-1:0] prot,
    input logic                cmd_ok,
    input logic                cmd_rej,
    input logic                miso_oe
);

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_ok && cmd_rej));

    p_ok_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |=> !cmd_ok);

    p_rej_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rej |=> !cmd_rej);

    p_ok_needs_wel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ok |-> (!wel && $past(wel)));

    p_wel_at_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wel) |-> $past(cs_rise));

    p_prot_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot) |-> ($past(cs_rise) && $past(wel)));

    p_strobe_at_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_ok || cmd_rej) |-> $past(cs_rise));

    p_oe_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> !miso_oe);

endmodule

bind spi_flash_cmd_frontend flash_cmd_checker #(.NUM_SECT(NUM_SECT)) i_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_rise(cs_rise),
    .wel    (wel),
    .prot   (prot),
    .cmd_ok (cmd_ok),
    .cmd_rej(cmd_rej),
    .miso_oe(spi_miso_oe)
);

// File: tb/test_spi_flash_cmd_frontend.sv
`timescale 1ns/1ps
module test_spi_flash_cmd_frontend;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_miso, spi_miso_oe, cmd_ok, cmd_rej;
    logic [7:0]  cmd_op;
    logic [23:0] cmd_addr;

    int n_chk = 0;
    int n_err = 0;
    int n_ok  = 0;
    int n_rej = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    spi_flash_cmd_frontend i_spi_flash_cmd_frontend (
        .clk        (clk),
        .rst_n      (rst_n),
        .spi_cs_n   (spi_cs_n),
        .spi_sclk   (spi_sclk),
        .spi_mosi   (spi_mosi),
        .spi_miso   (spi_miso),
        .spi_miso_oe(spi_miso_oe),
        .cmd_ok     (cmd_ok),
        .cmd_rej    (cmd_rej),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr)
    );

    always @(posedge clk) begin
        if (cmd_ok)  n_ok  <= n_ok + 1;
        if (cmd_rej) n_rej <= n_rej + 1;
    end

    typedef struct packed {
        logic [39:0] data;
        logic [7:0]  nbits;
        logic        wel;
        logic        ok;
        logic        rej;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        '{40'h02_050000_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 latch 0 -> reject
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},  // R2
        '{40'h04_AA0000_00, 8'd16, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 trailing byte
        '{40'h06_000000_00, 8'd7,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 short opcode
        '{40'h06_000000_00, 8'd9,  1'b0, 1'b0, 1'b0, 4'd4},  // R4 misaligned
        '{40'h06_000000_00, 8'd16, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 trailing byte
        '{40'h02_050000_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd9},  // R9 protected, latch clears
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h39_050000_00, 8'd24, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 short address
        '{40'h39_850000_00, 8'd32, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 unlock sector 5 (bit 23 ignored)
        '{40'h02_051234_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 latch 0
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h02_05ABCD_77, 8'd40, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 permitted with data byte
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'hD8_060000_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 sector 6 protected
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h20_05FFFF_00, 8'd33, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 misaligned
        '{40'h20_05FFFF_00, 8'd32, 1'b0, 1'b1, 1'b0, 4'd8},  // R8 erase permitted
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h36_050000_00, 8'd32, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 lock sector 5
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h02_050000_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 lock took effect
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'h9F_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd11}, // R11 unknown opcode
        '{40'h04_000000_00, 8'd4,  1'b1, 1'b0, 1'b0, 4'd4},  // R4 partial opcode
        '{40'h04_000000_00, 8'd8,  1'b0, 1'b0, 1'b0, 4'd3},  // R3
        '{40'h39_060000_00, 8'd32, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 unlock with latch 0
        '{40'h06_000000_00, 8'd8,  1'b1, 1'b0, 1'b0, 4'd2},
        '{40'hD8_060000_00, 8'd32, 1'b0, 1'b0, 1'b1, 4'd7}   // R7 sector 6 still locked
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Sends nbits from data (MSB first); captures miso for bits 8..23 and
    // records whether the output enable stayed high during the frame.
    task automatic spi_frame(input logic [39:0] data, input int nbits,
                             output logic [15:0] cap, output logic oe_hi);
        cap   = '0;
        oe_hi = 1'b1;
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = data[39-i];
            repeat (HALF) @(negedge clk);
            if (i >= 8 && i < 24) cap[23-i] = spi_miso;
            oe_hi = oe_hi & spi_miso_oe;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        spi_mosi = 1'b0;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic read_status(output logic [15:0] cap, output logic oe_hi);
        spi_frame(40'h05_000000_00, 24, cap, oe_hi);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        logic [15:0] cap;
        logic        oe_hi;
        int          ok0, rej0;

        do_reset();
        // R1 / R6: idle outputs after reset
        chk("R1 cmd_ok after reset", cmd_ok, 0);
        chk("R1 cmd_rej after reset", cmd_rej, 0);
        chk("R6 miso_oe idle", spi_miso_oe, 0);
        chk("R1 miso idle", spi_miso, 0);
        read_status(cap, oe_hi);
        chk("R1 status after reset", cap, 16'h0000);
        chk("R6 miso_oe during frame", oe_hi, 1);
        chk("R6 miso_oe after release", spi_miso_oe, 0);
        // R5: status repeats and carries the latch in bit 1
        spi_frame(40'h06_000000_00, 8, cap, oe_hi);
        read_status(cap, oe_hi);
        chk("R5 status with latch set (two bytes)", cap, 16'h0202);
        spi_frame(40'h04_000000_00, 8, cap, oe_hi);

        for (int v = 0; v < NV; v++) begin
            ok0  = n_ok;
            rej0 = n_rej;
            spi_frame(VECS[v].data, int'(VECS[v].nbits), cap, oe_hi);
            chk($sformatf("R%0d vec%0d permitted strobes", VECS[v].req, v), n_ok - ok0, VECS[v].ok);
            chk($sformatf("R%0d vec%0d rejected strobes", VECS[v].req, v), n_rej - rej0, VECS[v].rej);
            if (v == 12) begin
                chk("R8 cmd_op after program", cmd_op, 8'h02);
                chk("R8 cmd_addr after program", cmd_addr, 24'h05ABCD);
            end
            read_status(cap, oe_hi);
            chk($sformatf("R%0d vec%0d status", VECS[v].req, v), cap,
                VECS[v].wel ? 16'h0202 : 16'h0000);
        end
        chk("R8 cmd_op holds last request", cmd_op, 8'hD8);
        chk("R8 cmd_addr holds last request", cmd_addr, 24'h060000);

        // R1: reset restores protection of an unlocked sector (sector 9)
        spi_frame(40'h06_000000_00, 8, cap, oe_hi);
        spi_frame(40'h39_090000_00, 32, cap, oe_hi);
        spi_frame(40'h06_000000_00, 8, cap, oe_hi);
        ok0 = n_ok;
        spi_frame(40'h02_090010_00, 32, cap, oe_hi);
        chk("R7 sector 9 unlocked", n_ok - ok0, 1);
        do_reset();
        read_status(cap, oe_hi);
        chk("R1 latch cleared by reset", cap, 16'h0000);
        spi_frame(40'h06_000000_00, 8, cap, oe_hi);
        rej0 = n_rej;
        spi_frame(40'h02_090010_00, 32, cap, oe_hi);
        chk("R1 sector 9 protected again", n_rej - rej0, 1);
        spi_frame(40'h06_000000_00, 8, cap, oe_hi);
        rej0 = n_rej;
        spi_frame(40'h20_7F0000_00, 32, cap, oe_hi);
        chk("R1 top sector protected", n_rej - rej0, 1);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule